// File: doc/BRIEF.md
# RTC Calendar Register File

This block is the register bank of a real-time clock peripheral. It sits on a plain 32-bit word bus with an address, write enable, write data, read enable and registered read data. It holds four kinds of register:

- a calendar date word;
- a time-of-day word;
- an oscillator control word, in which two sticky flags record date and time writes that software has not yet seen;
- a set of scratch words.

The block does not advance time. Oscillator switching, alarm matching and interrupts belong to other blocks.

A compile-time parameter `LAYOUT` chooses one of two address maps. Each map has its own base year and its own number of scratch words.

While reset is asserted, the block samples the broken-out calendar inputs and packs them into the date and time encodings. These packed words become the date and time values after reset, if the base year is later than 1900.

Each cycle, the bus inputs are decoded into one of three access kinds:

| Access kind | Condition | Effect |
|---|---|---|
| `ACC_IDLE` | neither enable is high | nothing changes |
| `ACC_READ` | `rd_en` high, `wr_en` low | the selected word is captured into `rd_data` at the clock edge |
| `ACC_WRITE` | `wr_en` high, whatever `rd_en` is | the selected register is updated at the clock edge |

The access kind is worked out again every cycle, so any kind can follow any other.

Top module: `rtc_calendar_regs`

## Requirements
- R1: Reset clears the control word, every scratch word and `rd_data`. While reset is low, the date and time words take the packed reset inputs when `BASE_YEAR` > 1900; otherwise they are zero.
- R2: The packed date word is built as follows. Bits 31:16 hold `init_year - BASE_YEAR` modulo 2^16. Bits 15:8 hold the month (1..12). Bits 7:0 hold the day of month.
- R3: The packed time word is built as follows. Bits 31:29 hold the weekday, with Monday as 0 and Sunday as 6; the input `init_wday` counts Sunday as 0 through Saturday as 6. Bits 28:16 hold the hour, bits 15:8 the minute and bits 7:0 the second.
- R4: A write to the date address stores the whole 32-bit word and sets control bit 7.
- R5: A write to the time address stores the whole 32-bit word and sets control bit 8.
- R6: A read of the control address returns the current control word and clears bits 7 and 8 in the same access. All other control bits always read 0.
- R7: Writes to the control address have no effect.
- R8: In layout A (`LAYOUT`=0, base year 2010), the map is as follows: control at 0x000, date at 0x004, time at 0x008, and scratch words 0..3 at 0x020..0x02C.
- R9: In layout B (`LAYOUT`=1, base year 1970), the map is as follows: control at 0x000, date at 0x010, time at 0x014, and scratch words 0..7 at 0x100..0x11C. Scratch words keep what is written to them.
- R10: Any other address reads 0 and ignores writes. This includes alarm and configuration slots, offsets past the map, and any address whose bits 1:0 are nonzero.
- R11: Read data appears on `rd_data` after the clock edge of the `ACC_READ` cycle and holds in every other cycle.
- R12: When `wr_en` and `rd_en` are both high, only the write is performed and `rd_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the calendar inputs are sampled while it is low |
| addr | input | ADDR_W | Byte address of the word access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| init_year | input | 12 | Full calendar year for the reset load |
| init_month | input | 4 | Month, 1..12 |
| init_mday | input | 5 | Day of month, 1..31 |
| init_wday | input | 3 | Weekday, 0 = Sunday .. 6 = Saturday |
| init_hour | input | 5 | Hour, 0..23 |
| init_min | input | 6 | Minute, 0..59 |
| init_sec | input | 6 | Second, 0..59 |

## Verification
The following rules are checked on every cycle:

- a date or time write stores the word and raises its flag on the next edge;
- a control read clears both flags and returns the flags as they were before the read;
- unmapped reads return zero;
- `rd_data` holds in any cycle that is not a pure read.

The packing of year offset and weekday at reset can only be shown by the bench's scenarios, which reset with chosen calendar inputs. The same is true of the two address maps side by side, a base year at or below 1900, and the persistence of scratch words.

// File: rtl/rtc_regs_pkg.sv
`timescale 1ns/1ps
package rtc_regs_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_DATE,
        RK_TIME,
        RK_SCR
    } reg_kind_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_e;

    localparam int WORD_W     = 32;
    localparam int CTRL_OFF   = 'h000;
    localparam int FLAG_DATE  = 7;
    localparam int FLAG_TIME  = 8;

    function automatic int date_off(input int layout);
        return (layout == 0) ? 'h004 : 'h010;
    endfunction

    function automatic int time_off(input int layout);
        return (layout == 0) ? 'h008 : 'h014;
    endfunction

    function automatic int scr_base(input int layout);
        return (layout == 0) ? 'h020 : 'h100;
    endfunction

    function automatic int scr_count(input int layout);
        return (layout == 0) ? 4 : 8;
    endfunction

    function automatic int base_year(input int layout);
        return (layout == 0) ? 2010 : 1970;
    endfunction

endpackage

// File: rtl/rtc_time_pack.sv
`timescale 1ns/1ps
module rtc_time_pack #(
    parameter int BASE_YEAR = 1970
) (
    input  logic [11:0] year,
    input  logic [3:0]  month,
    input  logic [4:0]  mday,
    input  logic [2:0]  wday,
    input  logic [4:0]  hour,
    input  logic [5:0]  minute,
    input  logic [5:0]  second,
    output logic [31:0] date_word,
    output logic [31:0] time_word
);
    localparam logic [15:0] BASE16 = 16'(BASE_YEAR);

    logic [15:0] year_ofs;
    logic [3:0]  wd_sum;
    logic [2:0]  wd_mon0;

    always_comb begin
        year_ofs = {4'b0, year} - BASE16;
        // Shift the week so that Monday becomes 0 and Sunday becomes 6.
        wd_sum   = {1'b0, wday} + 4'd6;
        wd_mon0  = (wd_sum >= 4'd7) ? 3'(wd_sum - 4'd7) : wd_sum[2:0];
        date_word = {year_ofs, 4'b0, month, 3'b0, mday};
        time_word = {wd_mon0, 8'b0, hour, 2'b0, minute, 2'b0, second};
    end
endmodule

// File: rtl/rtc_addr_decode.sv
`timescale 1ns/1ps
module rtc_addr_decode
    import rtc_regs_pkg::*;
#(
    parameter int LAYOUT = 1,
    parameter int ADDR_W = 10,
    parameter int N_SCR  = scr_count(LAYOUT),
    parameter int IDX_W  = $clog2(N_SCR)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  scr_idx
);
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_OFF);
    localparam logic [ADDR_W-1:0] DATE_A   = ADDR_W'(date_off(LAYOUT));
    localparam logic [ADDR_W-1:0] TIME_A   = ADDR_W'(time_off(LAYOUT));
    localparam logic [ADDR_W-1:0] SCR_A    = ADDR_W'(scr_base(LAYOUT));
    localparam logic [ADDR_W-1:0] SCR_SPAN = ADDR_W'(4 * N_SCR);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel     = addr - SCR_A;
        kind    = RK_NONE;
        scr_idx = rel[IDX_W+1:2];
        if (addr == CTRL_A) begin
            kind = RK_CTRL;
        end else if (addr == DATE_A) begin
            kind = RK_DATE;
        end else if (addr == TIME_A) begin
            kind = RK_TIME;
        end else if (addr >= SCR_A && rel < SCR_SPAN && rel[1:0] == 2'b00) begin
            kind = RK_SCR;
        end
    end
endmodule

// File: rtl/rtc_scratch_bank.sv
`timescale 1ns/1ps
module rtc_scratch_bank #(
    parameter int N     = 8,
    parameter int W     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);
    logic [N*W-1:0] flat;

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                slot_q <= wdata;
            end
        end
        assign flat[g*W +: W] = slot_q;
    end

    assign rdata = flat[idx*W +: W];
endmodule

// File: rtl/rtc_calendar_regs.sv
`timescale 1ns/1ps
module rtc_calendar_regs
    import rtc_regs_pkg::*;
#(
    parameter int LAYOUT    = 1,
    parameter int ADDR_W    = 10,
    parameter int BASE_YEAR = base_year(LAYOUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic [11:0]       init_year,
    input  logic [3:0]        init_month,
    input  logic [4:0]        init_mday,
    input  logic [2:0]        init_wday,
    input  logic [4:0]        init_hour,
    input  logic [5:0]        init_min,
    input  logic [5:0]        init_sec
);
    localparam int N_SCR     = scr_count(LAYOUT);
    localparam int IDX_W     = $clog2(N_SCR);
    localparam bit LOAD_INIT = (BASE_YEAR > 1900);

    acc_e             acc;
    reg_kind_e        kind;
    logic [IDX_W-1:0] scr_idx;
    logic [31:0]      init_date;
    logic [31:0]      init_time;
    logic [31:0]      scr_rdata;
    logic [31:0]      ctrl_word;
    logic [31:0]      rd_mux;
    logic             scr_we;

    // pend_q[0] : date written, shown at control bit 7
    // pend_q[1] : time written, shown at control bit 8
    logic [1:0]       pend_q;
    logic [31:0]      date_q;
    logic [31:0]      time_q;
    logic [31:0]      rd_q;

    rtc_time_pack #(.BASE_YEAR(BASE_YEAR)) u_pack (
        .year      (init_year),
        .month     (init_month),
        .mday      (init_mday),
        .wday      (init_wday),
        .hour      (init_hour),
        .minute    (init_min),
        .second    (init_sec),
        .date_word (init_date),
        .time_word (init_time)
    );

    rtc_addr_decode #(
        .LAYOUT (LAYOUT),
        .ADDR_W (ADDR_W),
        .N_SCR  (N_SCR),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr    (addr),
        .kind    (kind),
        .scr_idx (scr_idx)
    );

    rtc_scratch_bank #(
        .N     (N_SCR),
        .W     (WORD_W),
        .IDX_W (IDX_W)
    ) u_scr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (scr_we),
        .idx   (scr_idx),
        .wdata (wr_data),
        .rdata (scr_rdata)
    );

    // A write takes precedence when both strobes are high.
    always_comb begin
        if (wr_en) begin
            acc = ACC_WRITE;
        end else if (rd_en) begin
            acc = ACC_READ;
        end else begin
            acc = ACC_IDLE;
        end
    end

    assign scr_we    = (acc == ACC_WRITE) && (kind == RK_SCR);
    assign ctrl_word = {23'b0, pend_q[1], pend_q[0], 7'b0};

    always_comb begin
        unique case (kind)
            RK_CTRL: rd_mux = ctrl_word;
            RK_DATE: rd_mux = date_q;
            RK_TIME: rd_mux = time_q;
            RK_SCR:  rd_mux = scr_rdata;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 2'b00;
            date_q <= LOAD_INIT ? init_date : '0;
            time_q <= LOAD_INIT ? init_time : '0;
            rd_q   <= '0;
        end else begin
            unique case (acc)
                ACC_WRITE: begin
                    if (kind == RK_DATE) begin
                        date_q    <= wr_data;
                        pend_q[0] <= 1'b1;
                    end else if (kind == RK_TIME) begin
                        time_q    <= wr_data;
                        pend_q[1] <= 1'b1;
                    end
                end
                ACC_READ: begin
                    rd_q <= rd_mux;
                    if (kind == RK_CTRL) begin
                        pend_q <= 2'b00;
                    end
                end
                ACC_IDLE: begin
                end
                default: begin
                end
            endcase
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/rtc_calendar_regs_chk.sv
`timescale 1ns/1ps
module rtc_calendar_regs_chk
    import rtc_regs_pkg::*;
#(
    parameter int LAYOUT = 1,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic [1:0]        pend,
    input logic [31:0]       date_w,
    input logic [31:0]       time_w
);
    localparam logic [ADDR_W-1:0] C_DATE = ADDR_W'(date_off(LAYOUT));
    localparam logic [ADDR_W-1:0] C_TIME = ADDR_W'(time_off(LAYOUT));
    localparam logic [ADDR_W-1:0] C_SLO  = ADDR_W'(scr_base(LAYOUT));
    localparam logic [ADDR_W-1:0] C_SHI  = ADDR_W'(scr_base(LAYOUT) + 4 * scr_count(LAYOUT));

    logic is_ctrl;
    logic mapped;
    logic pure_rd;

    always_comb begin
        is_ctrl = (addr == '0);
        mapped  = is_ctrl || addr == C_DATE || addr == C_TIME ||
                  (addr >= C_SLO && addr < C_SHI && addr[1:0] == 2'b00);
        pure_rd = rd_en && !wr_en;
    end

    AST_DATE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_DATE) |=> (date_w == $past(wr_data)));      // R4
    AST_DATE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_DATE) |=> pend[0]);                          // R4
    AST_TIME_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_TIME) |=> (time_w == $past(wr_data)));      // R5
    AST_TIME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == C_TIME) |=> pend[1]);                          // R5
    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pure_rd && is_ctrl) |=> (pend == 2'b00));                       // R6
    AST_CTRL_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (pure_rd && is_ctrl) |=> (rd_data == {23'b0, $past(pend), 7'b0})); // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pure_rd && !mapped) |=> (rd_data == 32'b0));                    // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pure_rd |=> $stable(rd_data));                                  // R11
endmodule

bind rtc_calendar_regs rtc_calendar_regs_chk #(
    .LAYOUT (LAYOUT),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pend    (pend_q),
    .date_w  (date_q),
    .time_w  (time_q)
);

// File: tb/rtc_calendar_regs_tb.sv
`timescale 1ns/1ps
module rtc_calendar_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [2:0]  wr_en = '0;   // 0: layout B, 1: layout A, 2: layout A with base 1900
    logic [2:0]  rd_en = '0;
    logic [31:0] rdata [3];
    logic [11:0] i_year  = 12'd2023;
    logic [3:0]  i_month = 4'd7;
    logic [4:0]  i_mday  = 5'd14;
    logic [2:0]  i_wday  = 3'd5;
    logic [4:0]  i_hour  = 5'd13;
    logic [5:0]  i_min   = 6'd45;
    logic [5:0]  i_sec   = 6'd30;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rtc_calendar_regs #(.LAYOUT(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en[0]), .wr_data(wdata),
        .rd_en(rd_en[0]), .rd_data(rdata[0]), .init_year(i_year), .init_month(i_month),
        .init_mday(i_mday), .init_wday(i_wday), .init_hour(i_hour), .init_min(i_min),
        .init_sec(i_sec));

    rtc_calendar_regs #(.LAYOUT(0)) u_dut_a (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en[1]), .wr_data(wdata),
        .rd_en(rd_en[1]), .rd_data(rdata[1]), .init_year(i_year), .init_month(i_month),
        .init_mday(i_mday), .init_wday(i_wday), .init_hour(i_hour), .init_min(i_min),
        .init_sec(i_sec));

    rtc_calendar_regs #(.LAYOUT(0), .BASE_YEAR(1900)) u_dut_z (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en[2]), .wr_data(wdata),
        .rd_en(rd_en[2]), .rd_data(rdata[2]), .init_year(i_year), .init_month(i_month),
        .init_mday(i_mday), .init_wday(i_wday), .init_hour(i_hour), .init_min(i_min),
        .init_sec(i_sec));

    typedef struct packed {
        logic        wr;
        logic [9:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 10'h000, 32'h0,          32'h0,          4'd1},   // R1 control clear
        '{1'b0, 10'h010, 32'h0,          32'h0035070E,   4'd2},   // R2 2023-07-14, base 1970
        '{1'b0, 10'h014, 32'h0,          32'h800D2D1E,   4'd3},   // R3 Fri 13:45:30
        '{1'b1, 10'h010, 32'h12345678,   32'h0,          4'd4},
        '{1'b0, 10'h000, 32'h0,          32'h00000080,   4'd4},   // R4 flag bit 7
        '{1'b0, 10'h000, 32'h0,          32'h0,          4'd6},   // R6 cleared
        '{1'b0, 10'h010, 32'h0,          32'h12345678,   4'd4},   // R4 stored
        '{1'b1, 10'h014, 32'hCAFEF00D,   32'h0,          4'd5},
        '{1'b1, 10'h010, 32'h00000101,   32'h0,          4'd4},
        '{1'b0, 10'h000, 32'h0,          32'h00000180,   4'd5},   // R5 both flags
        '{1'b0, 10'h000, 32'h0,          32'h0,          4'd6},   // R6 cleared
        '{1'b0, 10'h014, 32'h0,          32'hCAFEF00D,   4'd5},   // R5 stored
        '{1'b1, 10'h000, 32'hFFFFFFFF,   32'h0,          4'd7},
        '{1'b0, 10'h000, 32'h0,          32'h0,          4'd7},   // R7 ignored
        '{1'b1, 10'h100, 32'hA5A50001,   32'h0,          4'd9},
        '{1'b1, 10'h11C, 32'h5A5A0008,   32'h0,          4'd9},
        '{1'b0, 10'h100, 32'h0,          32'hA5A50001,   4'd9},   // R9 scratch 0
        '{1'b0, 10'h11C, 32'h0,          32'h5A5A0008,   4'd9},   // R9 scratch 7
        '{1'b0, 10'h104, 32'h0,          32'h0,          4'd9},   // R9 untouched
        '{1'b1, 10'h120, 32'h0000DEAD,   32'h0,          4'd10},
        '{1'b0, 10'h120, 32'h0,          32'h0,          4'd10},  // R10 past scratch
        '{1'b1, 10'h102, 32'h0000BEEF,   32'h0,          4'd10},
        '{1'b0, 10'h102, 32'h0,          32'h0,          4'd10},  // R10 misaligned
        '{1'b0, 10'h100, 32'h0,          32'hA5A50001,   4'd10},  // R10 write ignored
        '{1'b1, 10'h004, 32'h11111111,   32'h0,          4'd10},
        '{1'b0, 10'h004, 32'h0,          32'h0,          4'd10},  // R10 other layout's slot
        '{1'b0, 10'h000, 32'h0,          32'h0,          4'd10},  // R10 no flag from it
        '{1'b0, 10'h3FC, 32'h0,          32'h0,          4'd10}   // R10 top of window
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int t, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = '0; wr_en[t] = 1'b1; rd_en = '0;
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic bus_read(input int t, input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = '0; rd_en[t] = 1'b1; wr_en = '0;
        @(negedge clk);
        rd_en = '0;
        d = rdata[t];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        check("R1 rd_data after reset", rdata[0], 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                bus_write(0, VEC[i].a, VEC[i].d);
            end else begin
                bus_read(0, VEC[i].a, v);
                n_chk++;
                if (v !== VEC[i].e) begin
                    n_bad++;
                    $display("FAIL vector %0d R%0d actual=%08h expected=%08h",
                             i, VEC[i].req, v, VEC[i].e);
                end
            end
        end

        // R11: held across idle cycles
        bus_read(0, 10'h100, v);
        repeat (4) @(negedge clk);
        check("R11 hold after idle", rdata[0], 32'hA5A50001);

        // R12: simultaneous strobes, the write wins and rd_data is unchanged
        @(negedge clk);
        addr = 10'h010; wdata = 32'h00000077; wr_en = 3'b001; rd_en = 3'b001;
        @(negedge clk);
        wr_en = '0; rd_en = '0;
        check("R12 rd_data unchanged", rdata[0], 32'hA5A50001);
        bus_read(0, 10'h000, v);
        check("R12 flag from write", v, 32'h00000080);
        bus_read(0, 10'h010, v);
        check("R12 date written", v, 32'h00000077);

        // R8: layout A map and base year 2010
        bus_read(1, 10'h004, v);
        check("R8 A date", v, 32'h000D070E);
        bus_read(1, 10'h008, v);
        check("R8 A time", v, 32'h800D2D1E);
        bus_write(1, 10'h02C, 32'h0BADCAFE);
        bus_read(1, 10'h02C, v);
        check("R8 A scratch 3", v, 32'h0BADCAFE);
        bus_read(1, 10'h030, v);
        check("R8 A past scratch", v, 32'h0);
        bus_read(1, 10'h010, v);
        check("R8 A alarm slot zero", v, 32'h0);
        bus_write(1, 10'h008, 32'h1);
        bus_read(1, 10'h000, v);
        check("R8 A time flag", v, 32'h00000100);

        // R1: base year at or below 1900 leaves date and time zero
        bus_read(2, 10'h004, v);
        check("R1 no load date", v, 32'h0);
        bus_read(2, 10'h008, v);
        check("R1 no load time", v, 32'h0);

        // R2 R3: year before base wraps, Sunday becomes 6
        i_year = 12'd1969; i_month = 4'd12; i_mday = 5'd31; i_wday = 3'd0;
        i_hour = 5'd23; i_min = 6'd59; i_sec = 6'd59;
        do_reset();
        bus_read(0, 10'h010, v);
        check("R2 wrapped year", v, 32'hFFFF0C1F);
        bus_read(0, 10'h014, v);
        check("R3 Sunday encoding", v, 32'hC0173B3B);
        bus_read(0, 10'h100, v);
        check("R1 scratch cleared", v, 32'h0);
        bus_read(0, 10'h000, v);
        check("R1 control cleared", v, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule